// File: doc/BRIEF.md
# Fractional-N Pulse-Swallow Divider Controller

This block divides a fast input clock, which stands in for the output of a dual-modulus prescaler, by a fractional ratio. It produces one output pulse per divide cycle. The integer part of the ratio comes from a main count B and a swallow count A. For the first A periods of a cycle the internal prescaler model divides by P+1, and for the remaining periods it divides by P. The fractional part comes from a first-order delta-sigma accumulator. On every cycle boundary the accumulator adds the numerator FN and wraps modulo a denominator chosen by a reference-select bit: 1920 or 1968. Each wrap lengthens that one cycle by a single input clock, so over a full denominator span the average ratio is P*B + A + FN/den.

A one-clock load strobe captures new B, A, FN and reference-select values into a holding stage. The counters pick up the held values only at the next cycle boundary, so a cycle is never cut short. Illegal values are clamped to the nearest legal value and raise a configuration error flag. The flag reports the legality of the most recent load.

Top module: `fracn_swallow_div`

## Requirements
- R1: While reset is asserted, div_pulse, mod_ctl and cfg_err are 0. Reset empties the accumulator and leaves B=2, A=0, FN=0, ref_sel=0 held. The first cycle after reset therefore lasts 2*P clocks.
- R2: div_pulse is high for exactly one clock, the last clock of each divide cycle. A cycle lasts P*B + S clocks, where S = A + carry.
- R3: mod_ctl is high for the first S*(P+1) clocks of a cycle and low for the rest of it.
- R4: On each cycle boundary the accumulator first reduces its value below the denominator (den = 1920 when ref_sel=0, 1968 when ref_sel=1). It then adds FN. A sum of den or more subtracts den and sets carry=1 for the cycle now starting. Over den consecutive cycles, exactly FN of them are lengthened.
- R5: Values captured by a load strobe take effect only at the cycle boundary that follows the capture. The cycle in progress keeps its length and its mod_ctl pattern.
- R6: A loaded B below 2 is used as 2 and sets cfg_err.
- R7: A loaded A above the parameter AMAX is used as AMAX and sets cfg_err.
- R8: A loaded FN at or above den is used as den-1 and sets cfg_err.
- R9: A is further capped at B-1 when the clamped FN is nonzero, and at B when FN is 0. Then A+carry can never exceed B. A raw A above this cap sets cfg_err.
- R10: cfg_err changes only on a load strobe. It takes the value 1 if any of R6 to R9 applied to that load and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock (prescaler input) |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | One-clock strobe capturing the configuration inputs |
| b_in | input | BW | Main count B |
| a_in | input | AW | Swallow count A |
| fn_in | input | FW | Fractional numerator FN |
| ref_sel | input | 1 | Denominator select: 0 gives 1920, 1 gives 1968 |
| div_pulse | output | 1 | One-clock pulse on the last clock of each divide cycle |
| mod_ctl | output | 1 | Modulus control, high while the prescaler divides by P+1 |
| cfg_err | output | 1 | Last load held an out-of-range value |

## Verification
The assertions rely on the clamping stage alone to keep the counters legal. Any 4-, 3- or 11-bit word may therefore arrive on the configuration inputs, and the assertions on cycle length, accumulator range and modulus-control edges must hold for all of them. They also take it that load is a synchronous input sampled on the clock. The stimulus drives every input on the falling edge only. It deliberately loads values below, at and above each limit, so the clamps are exercised while the length bounds are being checked. A reset before the fractional run starts the accumulator from zero, and no reference switch falls inside a measured denominator span.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

  // Denominator chosen by the reference select.
  function automatic int unsigned den_sel(input bit r, input int unsigned d0, input int unsigned d1);
    return r ? d1 : d0;
  endfunction

  function automatic int unsigned clamp_b(input int unsigned b);
    return (b < 2) ? 2 : b;
  endfunction

  function automatic int unsigned clamp_fn(input int unsigned fn, input int unsigned den);
    return (fn >= den) ? den - 1 : fn;
  endfunction

  // Largest swallow count that still leaves room for a carry.
  function automatic int unsigned swallow_cap(input int unsigned b, input int unsigned fn);
    return (fn != 0) ? b - 1 : b;
  endfunction

  function automatic int unsigned clamp_a(input int unsigned a, input int unsigned amax,
                                          input int unsigned cap);
    int unsigned t;
    t = (a > amax) ? amax : a;
    return (t > cap) ? cap : t;
  endfunction

  // Prescaler reload: count P+1 clocks while swallowing, else P.
  function automatic int unsigned pre_reload(input bit swallow, input int unsigned p);
    return swallow ? p : p - 1;
  endfunction

endpackage

// File: rtl/fnd_cfg.sv
module fnd_cfg
  import fnd_pkg::*;
#(
  parameter int unsigned BW   = 4,
  parameter int unsigned AW   = 3,
  parameter int unsigned FW   = 11,
  parameter int unsigned AMAX = 7,
  parameter int unsigned DEN0 = 1920,
  parameter int unsigned DEN1 = 1968
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] b_in,
  input  logic [AW-1:0] a_in,
  input  logic [FW-1:0] fn_in,
  input  logic          ref_in,
  output logic [BW-1:0] held_b,
  output logic [AW-1:0] held_a,
  output logic [FW-1:0] held_fn,
  output logic          held_ref,
  output logic          err
);

  int unsigned den, b_c, fn_c, cap, a_c;
  logic        bad;

  always_comb begin
    den  = den_sel(ref_in, DEN0, DEN1);
    b_c  = clamp_b(32'(b_in));
    fn_c = clamp_fn(32'(fn_in), den);
    cap  = swallow_cap(b_c, fn_c);
    a_c  = clamp_a(32'(a_in), AMAX, cap);
    bad  = (32'(b_in) < 2) || (32'(a_in) > AMAX) || (32'(fn_in) >= den) || (32'(a_in) > cap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_b   <= BW'(2);
      held_a   <= '0;
      held_fn  <= '0;
      held_ref <= 1'b0;
      err      <= 1'b0;
    end else if (load) begin
      held_b   <= BW'(b_c);
      held_a   <= AW'(a_c);
      held_fn  <= FW'(fn_c);
      held_ref <= ref_in;
      err      <= bad;
    end
  end

endmodule

// File: rtl/fnd_sdm.sv
module fnd_sdm
  import fnd_pkg::*;
#(
  parameter int unsigned FW   = 11,
  parameter int unsigned DEN0 = 1920,
  parameter int unsigned DEN1 = 1968,
  localparam int unsigned DW  = FW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [FW-1:0] fn,
  input  logic          ref_sel,
  output logic          carry,
  output logic [DW-1:0] acc_q
);

  logic [DW-1:0] den, acc_r, sum, acc_n;

  always_comb begin
    den   = DW'(den_sel(ref_sel, DEN0, DEN1));
    acc_r = (acc_q >= den) ? acc_q - den : acc_q;
    sum   = acc_r + DW'(fn);
    carry = (sum >= den);
    acc_n = carry ? sum - den : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (step) acc_q <= acc_n;
  end

endmodule

// File: rtl/fnd_cnt.sv
module fnd_cnt
  import fnd_pkg::*;
#(
  parameter int unsigned P   = 8,
  parameter int unsigned BW  = 4,
  localparam int unsigned PW = $clog2(P + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] b_ld,
  input  logic [BW-1:0] sw_ld,
  output logic          boot,
  output logic          period_end,
  output logic          cyc_end,
  output logic          mod_ctl
);

  logic [PW-1:0] pre_q;
  logic [BW-1:0] b_q, s_q, s_dec;

  assign period_end = (pre_q == '0);
  assign cyc_end    = boot | (period_end & (b_q == BW'(1)));
  assign mod_ctl    = (s_q != '0);
  assign s_dec      = (s_q != '0) ? s_q - 1'b1 : s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot  <= 1'b1;
      pre_q <= '0;
      b_q   <= '0;
      s_q   <= '0;
    end else begin
      boot <= 1'b0;
      if (cyc_end) begin
        b_q   <= b_ld;
        s_q   <= sw_ld;
        pre_q <= PW'(pre_reload(sw_ld != '0, P));
      end else if (period_end) begin
        b_q   <= b_q - 1'b1;
        s_q   <= s_dec;
        pre_q <= PW'(pre_reload(s_dec != '0, P));
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/fracn_swallow_div.sv
module fracn_swallow_div #(
  parameter int unsigned P    = 8,
  parameter int unsigned BW   = 4,
  parameter int unsigned AW   = 3,
  parameter int unsigned FW   = 11,
  parameter int unsigned AMAX = 7,
  parameter int unsigned DEN0 = 1920,
  parameter int unsigned DEN1 = 1968
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] b_in,
  input  logic [AW-1:0] a_in,
  input  logic [FW-1:0] fn_in,
  input  logic          ref_sel,
  output logic          div_pulse,
  output logic          mod_ctl,
  output logic          cfg_err
);

  logic [BW-1:0] held_b, sw_ld;
  logic [AW-1:0] held_a;
  logic [FW-1:0] held_fn;
  logic          held_ref, carry, boot, period_end, cyc_end;
  logic [FW:0]   acc_q;

  fnd_cfg #(.BW(BW), .AW(AW), .FW(FW), .AMAX(AMAX), .DEN0(DEN0), .DEN1(DEN1)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load), .b_in(b_in), .a_in(a_in), .fn_in(fn_in),
    .ref_in(ref_sel), .held_b(held_b), .held_a(held_a), .held_fn(held_fn),
    .held_ref(held_ref), .err(cfg_err));

  fnd_sdm #(.FW(FW), .DEN0(DEN0), .DEN1(DEN1)) u_sdm (
    .clk(clk), .rst_n(rst_n), .step(cyc_end), .fn(held_fn), .ref_sel(held_ref),
    .carry(carry), .acc_q(acc_q));

  assign sw_ld = BW'(held_a) + BW'(carry);

  fnd_cnt #(.P(P), .BW(BW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .b_ld(held_b), .sw_ld(sw_ld), .boot(boot),
    .period_end(period_end), .cyc_end(cyc_end), .mod_ctl(mod_ctl));

  assign div_pulse = cyc_end & ~boot;

endmodule

// File: rtl/fnd_chk.sv
module fnd_chk #(
  parameter int unsigned P    = 8,
  parameter int unsigned BW   = 4,
  parameter int unsigned AW   = 3,
  parameter int unsigned FW   = 11,
  parameter int unsigned DEN1 = 1968
) (
  input logic        clk,
  input logic        rst_n,
  input logic        load,
  input logic        div_pulse,
  input logic        mod_ctl,
  input logic        cfg_err,
  input logic        period_end,
  input logic [FW:0] acc_q
);

  localparam int unsigned GAP_MIN = 2 * P;
  localparam int unsigned GAP_MAX = P * ((1 << BW) - 1) + (1 << AW);

  logic [15:0] gap;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (div_pulse) begin
      gap  <= 16'd1;
      seen <= 1'b1;
    end else if (gap != 16'hFFFF) begin
      gap  <= gap + 1'b1;
    end
  end

  assert_pulse_at_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> period_end);

  assert_gap_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_pulse && seen) |-> (32'(gap) >= GAP_MIN));

  assert_gap_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (div_pulse && seen) |-> (32'(gap) <= GAP_MAX));

  assert_mod_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mod_ctl) || $fell(mod_ctl)) |-> $past(period_end));

  assert_acc_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(acc_q) < DEN1);

  assert_err_on_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_err));

endmodule

bind fracn_swallow_div fnd_chk #(.P(P), .BW(BW), .AW(AW), .FW(FW), .DEN1(DEN1)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .div_pulse(div_pulse), .mod_ctl(mod_ctl),
  .cfg_err(cfg_err), .period_end(period_end), .acc_q(acc_q));

// File: tb/tb_fracn_swallow_div.sv
module tb_fracn_swallow_div;
  localparam int CLK_P = 10;
  localparam int P     = 8;
  localparam int AMAX  = 5;
  localparam int D0    = 1920;
  localparam int D1    = 1968;

  logic clk = 0, rst_n = 0, load = 0, ref_sel = 0;
  logic [3:0]  b_in = 0;
  logic [2:0]  a_in = 0;
  logic [10:0] fn_in = 0;
  logic div_pulse, mod_ctl, cfg_err;

  int checks = 0, errors = 0;
  string tag = "R1";

  // behavioural model state
  int m_boot, m_idx, m_len, m_sw, m_acc;
  int h_b, h_a, h_fn, h_ref, m_err;
  // interval measurement from the ports
  int gap_cnt, long_cnt, iv_cnt, measuring, long_len;

  fracn_swallow_div #(.P(P), .AMAX(AMAX), .DEN0(D0), .DEN1(D1)) dut (
    .clk(clk), .rst_n(rst_n), .load(load), .b_in(b_in), .a_in(a_in), .fn_in(fn_in),
    .ref_sel(ref_sel), .div_pulse(div_pulse), .mod_ctl(mod_ctl), .cfg_err(cfg_err));

  always #(CLK_P/2) clk = ~clk;

  task automatic check_eq(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_boot = 1; m_idx = 0; m_len = 1; m_sw = 0; m_acc = 0;
    h_b = 2; h_a = 0; h_fn = 0; h_ref = 0; m_err = 0;
  endtask

  task automatic model_edge();
    int den, c, nb, nfn, cap, na;
    if (m_boot == 1 || m_idx == m_len - 1) begin
      den   = h_ref ? D1 : D0;
      m_acc = m_acc % den + h_fn;
      c     = 0;
      if (m_acc >= den) begin m_acc -= den; c = 1; end
      m_len = P * h_b + h_a + c;
      m_sw  = h_a + c;
      m_idx = 0;
    end else m_idx++;
    m_boot = 0;
    if (load) begin
      den = ref_sel ? D1 : D0;
      nb  = b_in; if (nb < 2) nb = 2;
      nfn = fn_in; if (nfn >= den) nfn = den - 1;
      cap = nb; if (nfn != 0) cap = nb - 1;
      na  = a_in; if (na > AMAX) na = AMAX; if (na > cap) na = cap;
      m_err = (b_in < 2 || a_in > AMAX || fn_in >= den || a_in > cap) ? 1 : 0;
      h_b = nb; h_a = na; h_fn = nfn; h_ref = ref_sel;
    end
  endtask

  task automatic compare();
    int ep, em;
    ep = (!m_boot && m_idx == m_len - 1) ? 1 : 0;
    em = (!m_boot && m_idx < m_sw * (P + 1)) ? 1 : 0;
    check_eq(tag, "div_pulse", div_pulse, ep);
    check_eq(tag, "mod_ctl", mod_ctl, em);
    check_eq(tag, "cfg_err", cfg_err, m_err);
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
    compare();
    gap_cnt++;
    if (div_pulse) begin
      if (measuring) begin
        iv_cnt++;
        if (gap_cnt == long_len) long_cnt++;
      end
      gap_cnt = 0;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_load(input int b, input int a, input int fn, input int r);
    b_in = 4'(b); a_in = 3'(a); fn_in = 11'(fn); ref_sel = r[0];
    load = 1;
    tick();
    load = 0;
  endtask

  task automatic wait_pulse();
    for (int i = 0; i < 400 && !div_pulse; i++) tick();
  endtask

  task automatic do_reset();
    rst_n = 0;
    model_reset();
    @(negedge clk);
    compare();
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_P * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    gap_cnt = 0; long_cnt = 0; iv_cnt = 0; measuring = 0; long_len = 0;
    model_reset();
    // R1: outputs held low during reset, first cycle 2*P long
    tag = "R1";
    @(negedge clk);
    check_eq("R1", "div_pulse in reset", div_pulse, 0);
    check_eq("R1", "mod_ctl in reset", mod_ctl, 0);
    check_eq("R1", "cfg_err in reset", cfg_err, 0);
    @(negedge clk);
    rst_n = 1;
    run(40);

    // R2 R3: integer divide, swallow pattern
    tag = "R2";
    do_load(3, 1, 0, 0);
    run(90);
    tag = "R3";
    do_load(6, 5, 0, 1);
    run(200);

    // R5: load mid-cycle, current cycle keeps its shape
    tag = "R5";
    wait_pulse();
    run(10);
    do_load(2, 0, 0, 0);
    run(120);

    // R4: fractional part with a carry every few cycles
    tag = "R4";
    do_load(15, 4, 1000, 1);
    run(700);

    // R6: B below 2
    tag = "R6";
    do_load(1, 0, 0, 0);
    check_eq("R6", "cfg_err after B=1", cfg_err, 1);
    run(100);
    // R7: A above AMAX
    tag = "R7";
    do_load(10, 7, 0, 0);
    check_eq("R7", "cfg_err after A=7", cfg_err, 1);
    run(250);
    // R8: FN at or above the denominator
    tag = "R8";
    do_load(4, 1, 1950, 0);
    check_eq("R8", "cfg_err after FN=1950 ref0", cfg_err, 1);
    run(300);
    do_load(4, 1, 1950, 1);
    check_eq("R8", "cfg_err after FN=1950 ref1", cfg_err, 0);
    run(100);
    do_load(4, 1, 2047, 1);
    check_eq("R8", "cfg_err after FN=2047 ref1", cfg_err, 1);
    run(200);
    // R9: swallow cap depends on FN
    tag = "R9";
    do_load(4, 4, 3, 0);
    check_eq("R9", "cfg_err A=B with FN", cfg_err, 1);
    run(200);
    // R10: legal load clears the flag
    tag = "R10";
    do_load(4, 4, 0, 0);
    check_eq("R10", "cfg_err A=B no FN", cfg_err, 0);
    run(150);

    // R4: over one denominator span exactly FN cycles are lengthened
    tag = "R4";
    do_reset();
    do_load(3, 1, 100, 0);
    wait_pulse();
    tick();
    wait_pulse();
    long_len = P * 3 + 1 + 1;
    measuring = 1;
    while (iv_cnt < D0) tick();
    measuring = 0;
    check_eq("R4", "lengthened cycles in 1920", long_cnt, 100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule